// File: doc/BRIEF.md
# Shift-and-Add FIR Convolution Engine

This block produces one output sample of a programmable FIR filter without a multiplier. Every coefficient is a signed delay code: its magnitude picks a past input sample from a circular history buffer, and its sign decides whether that sample is added or subtracted. The coefficients are split into 16 groups. Each group adds up to a partial sum, and the partial sums are folded into a wide accumulator. A single 1-bit arithmetic right shift after every fold supplies the power-of-two weights, so no barrel shifter is needed.

The history buffer, the coefficient memory and the per-group count memory sit outside the block and are read through combinational read ports. They are loaded before a computation starts. The caller holds the write pointer, which marks the newest sample x(n), stable from `start_i` to `done_o`. The engine handles one coefficient per clock and then pulses `done_o` with the result on `y_o`.

Top module: `pot_fir_engine`

## Requirements
- R1: While `rst_ni` is low, and after it is released, `done_o` is 0 and `y_o` is 0 until the first computation completes.
- R2: A coefficient code is 9 bits wide. Bit 8 is the sign and bits 7:0 are a magnitude m that selects x(n-m) at history address (`wr_ptr_i` - m) mod 256. For example, code 0x0B4 with pointer 3 reads address 79.
- R3: A sign bit of 0 adds the selected sample to the group's partial sum. A sign bit of 1 subtracts it.
- R4: The count at `cnt_addr_o` = j gives how many consecutive codes form partial sum u_j. Groups run from j=15 down to j=0. Codes are read from coefficient address 0 upward, so group 15's codes come first and group 0's codes come last.
- R5: The accumulator is 40 bits wide and starts at 0. After each group it becomes (acc + u_j) arithmetically shifted right by one bit, rounding toward minus infinity. The final value is the result.
- R6: A group with a count of 0 adds nothing to the accumulator but still applies its 1-bit shift.
- R7: The engine handles one coefficient per clock. `done_o` is high for exactly one cycle, after the (33 + S)-th rising edge, where the edge that captures `start_i` is the first and S is the sum of the 16 counts.
- R8: `y_o` changes only together with a `done_o` pulse and holds the last result between computations.
- R9: A `start_i` pulse while a computation is running has no effect on that computation's result or timing.
- R10: History samples are 16-bit two's complement values, sign-extended before they are accumulated.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Start strobe, taken only when idle |
| wr_ptr_i | input | 8 | History address of the newest sample x(n) |
| hist_addr_o | output | 8 | History read address |
| hist_data_i | input | 16 | History read data (combinational) |
| cnt_addr_o | output | 4 | Group count memory address |
| cnt_data_i | input | 8 | Group count read data |
| coef_addr_o | output | 9 | Coefficient memory address |
| coef_data_i | input | 9 | Coefficient code read data |
| done_o | output | 1 | One-cycle completion pulse |
| y_o | output | 40 | Result, signed |

## Verification
A single group with one code at delay 0 isolates the final fold and halving. A lone code in group 1 compared with group 0 shows whether the code order and the power weights match. A subtracting code whose delay runs the pointer below zero separates the wrap of the address arithmetic from the sign handling, and negative odd samples show the floor rounding and sign extension. All-zero counts test the shift-only groups and the shortest latency. Runs with random memories and counts check sums and timing together, and a second start pulse in the middle of a run shows that it is ignored.

// File: rtl/pot_fir_pkg.sv
package pot_fir_pkg;
  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_GROUP = 2'd1,
    ST_ACCUM = 2'd2,
    ST_FOLD  = 2'd3
  } eng_state_e;
endpackage

// File: rtl/pot_fir_ctrl.sv
module pot_fir_ctrl
  import pot_fir_pkg::*;
#(
  parameter int GROUPS  = 16,
  parameter int CNT_W   = 8,
  parameter int COEF_AW = 9,
  parameter int GRP_W   = $clog2(GROUPS)
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               start_i,
  output logic [GRP_W-1:0]   cnt_addr_o,
  input  logic [CNT_W-1:0]   cnt_data_i,
  output logic [COEF_AW-1:0] coef_addr_o,
  output logic               clr_o,
  output logic               acc_en_o,
  output logic               fold_en_o,
  output logic               last_o
);
  localparam logic [GRP_W-1:0] GRP_TOP = GRP_W'(GROUPS - 1);

  eng_state_e         state_q;
  logic [GRP_W-1:0]   grp_q;
  logic [CNT_W-1:0]   rem_q;
  logic [COEF_AW-1:0] caddr_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      grp_q   <= '0;
      rem_q   <= '0;
      caddr_q <= '0;
    end else begin
      case (state_q)
        ST_IDLE: if (start_i) begin
          grp_q   <= GRP_TOP;
          caddr_q <= '0;
          state_q <= ST_GROUP;
        end
        ST_GROUP: begin
          rem_q   <= cnt_data_i;
          state_q <= (cnt_data_i == '0) ? ST_FOLD : ST_ACCUM;
        end
        ST_ACCUM: begin
          caddr_q <= caddr_q + 1'b1;
          rem_q   <= rem_q - 1'b1;
          if (rem_q == CNT_W'(1)) state_q <= ST_FOLD;
        end
        default: begin
          if (grp_q == '0) state_q <= ST_IDLE;
          else begin
            grp_q   <= grp_q - 1'b1;
            state_q <= ST_GROUP;
          end
        end
      endcase
    end
  end

  assign cnt_addr_o  = grp_q;
  assign coef_addr_o = caddr_q;
  assign clr_o       = (state_q == ST_IDLE) && start_i;
  assign acc_en_o    = (state_q == ST_ACCUM);
  assign fold_en_o   = (state_q == ST_FOLD);
  assign last_o      = fold_en_o && (grp_q == '0);

  // one coefficient consumed per accumulate cycle
  p_one_op_per_clk_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    acc_en_o |=> coef_addr_o == COEF_AW'($past(coef_addr_o) + 1'b1));

  p_group_descends_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fold_en_o && !last_o) |=> cnt_addr_o == GRP_W'($past(cnt_addr_o) - 1'b1));

  p_run_continues_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q != ST_IDLE && !last_o) |=> state_q != ST_IDLE);
endmodule

// File: rtl/pot_fir_tap.sv
module pot_fir_tap #(
  parameter int SAMPLE_W = 16,
  parameter int MAG_W    = 8,
  parameter int ACC_W    = 40
) (
  input  logic [MAG_W:0]           coef_i,
  input  logic [MAG_W-1:0]         wr_ptr_i,
  input  logic [SAMPLE_W-1:0]      hist_data_i,
  output logic [MAG_W-1:0]         hist_addr_o,
  output logic signed [ACC_W-1:0]  term_o
);
  localparam int EXT_W = ACC_W - SAMPLE_W;

  logic signed [ACC_W-1:0] samp_ext;

  // circular history: x(n-m) sits m entries behind the write pointer
  assign hist_addr_o = wr_ptr_i - coef_i[MAG_W-1:0];
  assign samp_ext    = {{EXT_W{hist_data_i[SAMPLE_W-1]}}, hist_data_i};
  assign term_o      = coef_i[MAG_W] ? -samp_ext : samp_ext;
endmodule

// File: rtl/pot_fir_datapath.sv
module pot_fir_datapath #(
  parameter int ACC_W = 40
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic                    clr_i,
  input  logic                    acc_en_i,
  input  logic                    fold_en_i,
  input  logic                    last_i,
  input  logic signed [ACC_W-1:0] term_i,
  output logic signed [ACC_W-1:0] y_o,
  output logic                    done_o
);
  logic signed [ACC_W-1:0] usum_q, acc_q, fold_val;

  always_comb fold_val = (acc_q + usum_q) >>> 1;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      usum_q <= '0;
      acc_q  <= '0;
      y_o    <= '0;
      done_o <= 1'b0;
    end else begin
      done_o <= last_i;
      if (clr_i) begin
        usum_q <= '0;
        acc_q  <= '0;
      end else if (acc_en_i) begin
        usum_q <= usum_q + term_i;
      end else if (fold_en_i) begin
        usum_q <= '0;
        acc_q  <= fold_val;
      end
      if (last_i) y_o <= fold_val;
    end
  end

  p_done_single_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);

  p_hold_out_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !done_o |-> $stable(y_o));

  p_acc_fold_excl_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(acc_en_i && fold_en_i));
endmodule

// File: rtl/pot_fir_engine.sv
module pot_fir_engine #(
  parameter int SAMPLE_W = 16,
  parameter int MAG_W    = 8,
  parameter int GROUPS   = 16,
  parameter int CNT_W    = 8,
  parameter int COEF_AW  = 9,
  parameter int ACC_W    = 40,
  parameter int GRP_W    = $clog2(GROUPS)
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                start_i,
  input  logic [MAG_W-1:0]    wr_ptr_i,
  output logic [MAG_W-1:0]    hist_addr_o,
  input  logic [SAMPLE_W-1:0] hist_data_i,
  output logic [GRP_W-1:0]    cnt_addr_o,
  input  logic [CNT_W-1:0]    cnt_data_i,
  output logic [COEF_AW-1:0]  coef_addr_o,
  input  logic [MAG_W:0]      coef_data_i,
  output logic                done_o,
  output logic [ACC_W-1:0]    y_o
);
  logic clr, acc_en, fold_en, last;
  logic signed [ACC_W-1:0] term, y_s;

  pot_fir_ctrl #(
    .GROUPS(GROUPS), .CNT_W(CNT_W), .COEF_AW(COEF_AW), .GRP_W(GRP_W)
  ) i_ctrl (
    .clk_i(clk_i), .rst_ni(rst_ni), .start_i(start_i),
    .cnt_addr_o(cnt_addr_o), .cnt_data_i(cnt_data_i),
    .coef_addr_o(coef_addr_o), .clr_o(clr), .acc_en_o(acc_en),
    .fold_en_o(fold_en), .last_o(last)
  );

  pot_fir_tap #(
    .SAMPLE_W(SAMPLE_W), .MAG_W(MAG_W), .ACC_W(ACC_W)
  ) i_tap (
    .coef_i(coef_data_i), .wr_ptr_i(wr_ptr_i), .hist_data_i(hist_data_i),
    .hist_addr_o(hist_addr_o), .term_o(term)
  );

  pot_fir_datapath #(.ACC_W(ACC_W)) i_dp (
    .clk_i(clk_i), .rst_ni(rst_ni), .clr_i(clr), .acc_en_i(acc_en),
    .fold_en_i(fold_en), .last_i(last), .term_i(term),
    .y_o(y_s), .done_o(done_o)
  );

  assign y_o = y_s;
endmodule

// File: tb/test_pot_fir_engine.sv
module test_pot_fir_engine;
  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic        start = 1'b0;
  logic [7:0]  wr_ptr = '0;
  logic [7:0]  hist_addr;
  logic [3:0]  cnt_addr;
  logic [8:0]  coef_addr;
  logic        done;
  logic [39:0] y;

  logic [15:0] hist_m [256];
  logic [8:0]  coef_m [512];
  logic [7:0]  cnt_m  [16];

  int    n_cmp = 0, n_bad = 0, cyc = 0;
  string cur_req = "R1";
  bit    fin = 1'b0;

  // reference model state
  bit    busy_m = 1'b0, exp_done = 1'b0;
  longint exp_y = 0, pend_y = 0;
  int    left = 0;

  always #4 clk = ~clk;

  pot_fir_engine i_pot_fir_engine (
    .clk_i(clk), .rst_ni(rst_ni), .start_i(start), .wr_ptr_i(wr_ptr),
    .hist_addr_o(hist_addr), .hist_data_i(hist_m[hist_addr]),
    .cnt_addr_o(cnt_addr), .cnt_data_i(cnt_m[cnt_addr]),
    .coef_addr_o(coef_addr), .coef_data_i(coef_m[coef_addr]),
    .done_o(done), .y_o(y)
  );

  function automatic longint ref_result();
    longint acc = 0;
    int a = 0;
    for (int g = 15; g >= 0; g--) begin
      longint u = 0;
      for (int k = 0; k < int'(cnt_m[g]); k++) begin
        logic [8:0] code = coef_m[a];
        logic [7:0] idx  = wr_ptr - code[7:0];
        longint s = longint'($signed(hist_m[idx]));
        u = code[8] ? u - s : u + s;
        a++;
      end
      acc = (acc + u) >>> 1;
    end
    return acc;
  endfunction

  function automatic int count_sum();
    int s = 0;
    for (int g = 0; g < 16; g++) s += int'(cnt_m[g]);
    return s;
  endfunction

  always @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_m = 0; exp_done = 0; exp_y = 0; left = 0;
    end else if (busy_m) begin
      left--;
      if (left == 0) begin
        exp_done = 1; exp_y = pend_y; busy_m = 0;
      end else exp_done = 0;
    end else begin
      exp_done = 0;
      if (start) begin
        busy_m = 1; left = 32 + count_sum(); pend_y = ref_result();
      end
    end
  end

  task automatic check(input bit ok, input string req, input longint act, input longint expv);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d (t=%0t)", req, act, expv, $time);
    end
  endtask

  always @(negedge clk) begin
    if (rst_ni && !fin) begin
      check(done == exp_done, "R7 done", longint'(done), longint'(exp_done));
      check(longint'($signed(y)) == exp_y, exp_done ? cur_req : "R8",
            longint'($signed(y)), exp_y);
    end
  end

  task automatic finish_run();
    fin = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000 && !fin) begin
      n_bad++;
      $display("FAIL watchdog: actual %0d expected <150000 cycles", cyc);
      finish_run();
    end
  end

  task automatic clear_mems();
    for (int i = 0; i < 256; i++) hist_m[i] = 16'(i * 37 + 11);
    for (int i = 0; i < 512; i++) coef_m[i] = '0;
    for (int i = 0; i < 16; i++)  cnt_m[i]  = '0;
  endtask

  task automatic pulse_start();
    @(negedge clk); start = 1'b1;
    @(negedge clk); start = 1'b0;
  endtask

  task automatic wait_idle();
    while (busy_m) @(negedge clk);
    repeat (3) @(negedge clk);
  endtask

  task automatic run(input string req);
    cur_req = req;
    pulse_start();
    wait_idle();
  endtask

  task automatic fill_random(input int maxcnt);
    for (int i = 0; i < 256; i++) hist_m[i] = 16'($urandom);
    for (int i = 0; i < 512; i++) coef_m[i] = 9'($urandom);
    for (int i = 0; i < 16; i++)  cnt_m[i]  = 8'($urandom_range(maxcnt, 0));
    wr_ptr = 8'($urandom);
  endtask

  initial begin
    clear_mems();
    repeat (3) @(negedge clk);
    // R1: outputs quiet in and after reset
    check(done == 1'b0, "R1 done in reset", longint'(done), 0);
    check(y == '0, "R1 y in reset", longint'($signed(y)), 0);
    rst_ni = 1'b1;
    repeat (2) @(negedge clk);
    check(done == 1'b0 && y == '0, "R1 after reset", longint'($signed(y)), 0);

    // R6/R5: only group 0 used, delay 0, 100 -> 50
    wr_ptr = 8'd10; hist_m[10] = 16'd100; cnt_m[0] = 8'd1; coef_m[0] = 9'h000;
    run("R6");
    check(longint'($signed(y)) == 50, "R5 single fold", longint'($signed(y)), 50);

    // R4: lone code in group 1 weighs half of group 0
    cnt_m[0] = 8'd0; cnt_m[1] = 8'd1; hist_m[10] = 16'd1000;
    run("R4");
    check(longint'($signed(y)) == 250, "R4 group weight", longint'($signed(y)), 250);

    // R4: group 15 codes come first in coefficient memory
    cnt_m[1] = 8'd0; cnt_m[15] = 8'd1; cnt_m[0] = 8'd1;
    coef_m[0] = 9'h005; coef_m[1] = 9'h000;
    hist_m[5] = 16'd7; hist_m[10] = 16'd2000;
    run("R4");

    // R2/R3: subtract, address wraps: 3 - 180 -> 79
    clear_mems();
    wr_ptr = 8'd3; hist_m[79] = 16'(-1234); cnt_m[0] = 8'd1; coef_m[0] = 9'h1B4;
    run("R3");
    check(longint'($signed(y)) == 617, "R2 wrapped subtract", longint'($signed(y)), 617);

    // R2 add of same tap
    coef_m[0] = 9'h0B4;
    run("R2");
    check(longint'($signed(y)) == -617, "R2 wrapped add", longint'($signed(y)), -617);

    // R10/R5: negative odd samples, floor rounding
    hist_m[79] = 16'h8001; cnt_m[0] = 8'd3; coef_m[1] = 9'h0B4; coef_m[2] = 9'h000;
    hist_m[3] = 16'hFFFF;
    run("R10");

    // R6/R7: all counts zero, shortest latency
    for (int i = 0; i < 16; i++) cnt_m[i] = '0;
    run("R6");

    // R7: random memories and counts
    for (int t = 0; t < 12; t++) begin
      fill_random(t < 6 ? 4 : 31);
      run("R7");
    end

    // R9: extra start pulses mid-run are ignored
    fill_random(20);
    cur_req = "R9";
    pulse_start();
    repeat (10) @(negedge clk);
    pulse_start();
    repeat (40) @(negedge clk);
    pulse_start();
    wait_idle();

    finish_run();
  end
endmodule